// File: doc/BRIEF.md
# UART Baud Source Selector

This block produces the bit-rate timing for a UART. It contains four free-running auto-reload timers: one narrow timer (8 bits by default) and three wide timers (16 bits by default). Each timer counts only in cycles where its enable input is high. When a timer rolls over from all ones to zero, it reloads from its own reload register and emits a one-cycle overflow pulse.

The transmit path and the receive path each pick one of the four overflow streams on their own. Each path then divides that stream down to a baud tick. On the narrow timer path only, a halving control adds a further divide-by-two. The receive path also brings out its 16x oversample tick, which is the selected overflow stream after the halving stage.

A single write port loads the four reload registers and a small control register. The control register holds the two source selects and the halving bit. A new reload value takes effect at the timer's next rollover.

Top module: `uart_baud_select`

## Requirements
- R1: While reset is asserted, and in the cycle after it is released, `tx_tick`, `rx_tick` and `rx_os_tick` are low. Reset clears the control register, so both selects are 00 and the halving bit is 0. With these defaults, both paths run from the narrow timer at its overflow rate divided by 32.
- R2: The narrow timer overflows once every (2^NARROW_W − reload) enabled cycles, once its reload value has been loaded at a rollover.
- R3: Each wide timer overflows once every (2^WIDE_W − reload) enabled cycles, once its reload value has been loaded at a rollover.
- R4: The source encoding is 00 = narrow timer, 01 = wide timer A, 10 = wide timer B, 11 = wide timer C. The transmit select and the receive select act independently of each other.
- R5: With the narrow timer selected, the baud tick period is 32 overflow periods when the halving bit is 0 and 16 overflow periods when it is 1.
- R6: With a wide timer selected, the baud tick period is 16 overflow periods, and changing the halving bit has no effect on the tick stream.
- R7: `rx_os_tick` pulses once for each overflow that passes the halving stage. `rx_tick` pulses together with every 16th `rx_os_tick`, so exactly 16 oversample ticks fall between receive ticks.
- R8: Every tick output is high for exactly one cycle at a time.
- R9: A timer advances only in cycles where its enable input is high. Halving the enable rate doubles the tick period.
- R10: Writes with `cfg_we` high use these addresses:
  - address 0 loads the narrow reload register from `cfg_wdata[7:0]`;
  - addresses 1, 2 and 3 load wide timers A, B and C from `cfg_wdata[15:0]`;
  - address 4 loads the control register, with tx select in `cfg_wdata[1:0]`, rx select in `cfg_wdata[3:2]` and the halving bit in `cfg_wdata[4]`.

  A reload write does not disturb the period already in progress. The new value applies from the next rollover.
- R11: A change of a path's select clears that path's prescaler and suppresses any tick in the cycle after the change. As a result, the first tick from the new source comes no sooner than (divisor − 1) of its overflow periods after the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| narrow_en | input | 1 | Count enable pulse for the narrow timer |
| wide_en | input | 3 | Count enable pulses for wide timers A (bit 0), B, C |
| cfg_we | input | 1 | Write strobe for reload/control registers |
| cfg_addr | input | 3 | Register address (0 narrow, 1–3 wide, 4 control) |
| cfg_wdata | input | 16 | Write data |
| tx_tick | output | 1 | One-cycle transmit baud tick |
| rx_tick | output | 1 | One-cycle receive baud tick |
| rx_os_tick | output | 1 | One-cycle receive 16x oversample tick |

## Verification
The assertions assume that overflows occur only after a cycle in which the corresponding timer enable was high. They also assume that no source overflows so often that a divided tick would repeat in consecutive cycles. The stimulus respects this by using reload values that give overflow periods of at least four cycles. It keeps the selects stable for many baud periods and writes registers only at single, spaced-out cycles. It drives the enables either held high or toggled on alternate cycles, so every interval the scoreboard expects can be derived exactly from the reload value and the divisor.

// File: rtl/uart_baud_select_pkg.sv
package uart_baud_select_pkg;
   typedef enum logic [1:0] {
      SRC_NARROW = 2'b00,
      SRC_WIDE_A = 2'b01,
      SRC_WIDE_B = 2'b10,
      SRC_WIDE_C = 2'b11
   } src_sel_e;

   typedef struct packed {
      logic     half;
      src_sel_e rx_sel;
      src_sel_e tx_sel;
   } ctrl_t;

   localparam int CTRL_BITS = $bits(ctrl_t);
   localparam logic [2:0] ADDR_CTRL = 3'd4;
endpackage

// File: rtl/baudsel_timer.sv
module baudsel_timer #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         en,
   input  logic         ld_we,
   input  logic [W-1:0] ld_val,
   output logic         ovf
);
   localparam logic [W-1:0] ALL_ONES = '1;

   if (W < 2) begin : g_bad_width
      $error("baudsel_timer: W must be at least 2");
   end

   logic [W-1:0] cnt_q;
   logic [W-1:0] rld_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
         rld_q <= '0;
         ovf   <= 1'b0;
      end else begin
         ovf <= 1'b0;
         if (ld_we) rld_q <= ld_val;
         if (en) begin
            if (cnt_q == ALL_ONES) begin
               cnt_q <= rld_q;
               ovf   <= 1'b1;
            end else begin
               cnt_q <= cnt_q + 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/baudsel_gate.sv
module baudsel_gate
   import uart_baud_select_pkg::*;
#(
   parameter int N_SRC = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  src_sel_e         src_sel,
   input  logic             half,
   input  logic [N_SRC-1:0] ovf_vec,
   output logic             pass,
   output logic             restart
);
   src_sel_e sel_q;
   logic     phase_q;
   logic     hit;
   logic     need_half;

   assign hit       = ovf_vec[src_sel];
   assign need_half = (src_sel == SRC_NARROW) && !half;
   assign restart   = (src_sel != sel_q);
   assign pass      = hit && !restart && (!need_half || phase_q);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sel_q   <= SRC_NARROW;
         phase_q <= 1'b0;
      end else begin
         sel_q <= src_sel;
         if (restart)
            phase_q <= 1'b0;
         else if (hit && need_half)
            phase_q <= ~phase_q;
      end
   end
endmodule

// File: rtl/baudsel_div.sv
module baudsel_div #(
   parameter int RATIO = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic step,
   output logic tick
);
   localparam int CW = (RATIO > 1) ? $clog2(RATIO) : 1;
   localparam logic [CW-1:0] LAST = CW'(RATIO - 1);

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
         tick  <= 1'b0;
      end else begin
         tick <= 1'b0;
         if (clr) begin
            cnt_q <= '0;
         end else if (step) begin
            cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
            if (cnt_q == LAST) tick <= 1'b1;
         end
      end
   end
endmodule

// File: rtl/uart_baud_select.sv
module uart_baud_select
   import uart_baud_select_pkg::*;
#(
   parameter int NARROW_W = 8,
   parameter int WIDE_W   = 16,
   parameter int N_WIDE   = 3,
   parameter int OS_RATIO = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              narrow_en,
   input  logic [N_WIDE-1:0] wide_en,
   input  logic              cfg_we,
   input  logic [2:0]        cfg_addr,
   input  logic [WIDE_W-1:0] cfg_wdata,
   output logic              tx_tick,
   output logic              rx_tick,
   output logic              rx_os_tick
);
   localparam int N_SRC = N_WIDE + 1;

   if (N_WIDE != 3) begin : g_bad_count
      $error("uart_baud_select: two-bit selects need exactly three wide timers");
   end
   if (NARROW_W < 2 || WIDE_W <= NARROW_W || WIDE_W < CTRL_BITS) begin : g_bad_width
      $error("uart_baud_select: illegal timer widths");
   end
   if (OS_RATIO < 2 || (OS_RATIO & (OS_RATIO - 1)) != 0) begin : g_bad_ratio
      $error("uart_baud_select: OS_RATIO must be a power of two");
   end

   ctrl_t            ctrl_q;
   logic [N_SRC-1:0] ovf_vec;
   logic             tx_pass, tx_restart;
   logic             rx_pass, rx_restart;

   // control register
   always_ff @(posedge clk) begin
      if (!rst_n)
         ctrl_q <= '0;
      else if (cfg_we && cfg_addr == ADDR_CTRL)
         ctrl_q <= ctrl_t'(cfg_wdata[CTRL_BITS-1:0]);
   end

   baudsel_timer #(.W(NARROW_W)) u_narrow (
      .clk    (clk),
      .rst_n  (rst_n),
      .en     (narrow_en),
      .ld_we  (cfg_we && cfg_addr == 3'd0),
      .ld_val (cfg_wdata[NARROW_W-1:0]),
      .ovf    (ovf_vec[0])
   );

   for (genvar gi = 0; gi < N_WIDE; gi++) begin : g_wide
      baudsel_timer #(.W(WIDE_W)) u_wide (
         .clk    (clk),
         .rst_n  (rst_n),
         .en     (wide_en[gi]),
         .ld_we  (cfg_we && cfg_addr == 3'(gi + 1)),
         .ld_val (cfg_wdata),
         .ovf    (ovf_vec[gi+1])
      );
   end

   baudsel_gate #(.N_SRC(N_SRC)) u_tx_gate (
      .clk     (clk),
      .rst_n   (rst_n),
      .src_sel (ctrl_q.tx_sel),
      .half    (ctrl_q.half),
      .ovf_vec (ovf_vec),
      .pass    (tx_pass),
      .restart (tx_restart)
   );

   baudsel_div #(.RATIO(OS_RATIO)) u_tx_div (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (tx_restart),
      .step  (tx_pass),
      .tick  (tx_tick)
   );

   baudsel_gate #(.N_SRC(N_SRC)) u_rx_gate (
      .clk     (clk),
      .rst_n   (rst_n),
      .src_sel (ctrl_q.rx_sel),
      .half    (ctrl_q.half),
      .ovf_vec (ovf_vec),
      .pass    (rx_pass),
      .restart (rx_restart)
   );

   baudsel_div #(.RATIO(OS_RATIO)) u_rx_div (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (rx_restart),
      .step  (rx_pass),
      .tick  (rx_tick)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) rx_os_tick <= 1'b0;
      else        rx_os_tick <= rx_pass;
   end
endmodule

// File: rtl/uart_baud_select_chk.sv
module uart_baud_select_chk #(
   parameter int N_WIDE = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic              tx_tick,
   input logic              rx_tick,
   input logic              rx_os_tick,
   input logic [1:0]        tx_sel,
   input logic              ovf_narrow,
   input logic              narrow_en,
   input logic [N_WIDE-1:0] wide_en
);
   // R8
   tx_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tx_tick |=> !tx_tick);

   // R8
   rx_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rx_tick |=> !rx_tick);

   // R7
   rx_on_os_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rx_tick |-> rx_os_tick);

   // R11
   tx_sel_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_sel != $past(tx_sel)) |=> !tx_tick);

   // R9
   narrow_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_narrow |-> $past(narrow_en));

   // R9
   tx_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tx_tick |-> $past(narrow_en || (|wide_en), 2));
endmodule

bind uart_baud_select uart_baud_select_chk #(.N_WIDE(N_WIDE)) chk_i (
   .clk        (clk),
   .rst_n      (rst_n),
   .tx_tick    (tx_tick),
   .rx_tick    (rx_tick),
   .rx_os_tick (rx_os_tick),
   .tx_sel     (ctrl_q.tx_sel),
   .ovf_narrow (ovf_vec[0]),
   .narrow_en  (narrow_en),
   .wide_en    (wide_en)
);

// File: tb/uart_baud_select_tb_top.sv
module uart_baud_select_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        narrow_en = 1'b1;
   logic [2:0]  wide_en = 3'b111;
   logic        cfg_we = 1'b0;
   logic [2:0]  cfg_addr = '0;
   logic [15:0] cfg_wdata = '0;
   logic        tx_tick, rx_tick, rx_os_tick;

   always #4 clk = ~clk;

   uart_baud_select dut_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .narrow_en  (narrow_en),
      .wide_en    (wide_en),
      .cfg_we     (cfg_we),
      .cfg_addr   (cfg_addr),
      .cfg_wdata  (cfg_wdata),
      .tx_tick    (tx_tick),
      .rx_tick    (rx_tick),
      .rx_os_tick (rx_os_tick)
   );

   typedef struct {
      int    iv;
      string tag;
   } exp_t;

   exp_t   q_tx[$];
   exp_t   q_rx[$];
   int     checks = 0;
   int     errors = 0;
   longint cyc = 0;
   longint last_tx = 0, last_rx = 0, mark_tx = 0, mark_rx = 0;
   int     bound_tx = 0, bound_rx = 0;
   bit     sync_tx = 1, sync_rx = 1;
   bit     prev_tx = 0, prev_rx = 0, prev_os = 0;
   int     os_since = 0;
   int     wide_ticks = 0;
   bit     en_toggle = 0;
   bit     done = 0;

   task automatic check(bit ok, string tag, longint act, longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // enable generator: held high, or toggled every cycle
   always begin
      @(posedge clk);
      #1;
      narrow_en = en_toggle ? ~narrow_en : 1'b1;
   end

   // monitor / scoreboard
   always @(negedge clk) begin
      if (!rst_n) begin
         prev_tx = 0; prev_rx = 0; prev_os = 0;
      end else begin
         exp_t e;
         cyc++;
         if ((tx_tick && prev_tx) || (rx_tick && prev_rx) || (rx_os_tick && prev_os))
            wide_ticks++;
         prev_tx = tx_tick; prev_rx = rx_tick; prev_os = rx_os_tick;
         if (rx_os_tick) os_since++;
         if (tx_tick) begin
            if (sync_tx) begin
               if (bound_tx > 0)
                  check(cyc - mark_tx >= bound_tx, "R11 first tx tick after select change",
                        cyc - mark_tx, bound_tx);
               sync_tx = 0;
            end else if (q_tx.size() > 0) begin
               e = q_tx.pop_front();
               check(cyc - last_tx == e.iv, e.tag, cyc - last_tx, e.iv);
            end
            last_tx = cyc;
         end
         if (rx_tick) begin
            if (sync_rx) begin
               if (bound_rx > 0)
                  check(cyc - mark_rx >= bound_rx, "R11 first rx tick after select change",
                        cyc - mark_rx, bound_rx);
               sync_rx = 0;
            end else if (q_rx.size() > 0) begin
               e = q_rx.pop_front();
               check(cyc - last_rx == e.iv, e.tag, cyc - last_rx, e.iv);
               check(os_since == 16, "R7 oversample ticks per rx tick", os_since, 16);
            end
            last_rx = cyc;
            os_since = 0;
         end
      end
   end

   task automatic wr(input logic [2:0] a, input logic [15:0] d);
      @(posedge clk);
      #1;
      cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
      @(posedge clk);
      #1;
      cfg_we = 1'b0;
   endtask

   task automatic set_ctrl(input logic [1:0] tx, input logic [1:0] rx, input logic half);
      wr(3'd4, {11'b0, half, rx, tx});
   endtask

   task automatic resync(input int btx, input int brx);
      q_tx.delete(); q_rx.delete();
      sync_tx = 1; sync_rx = 1;
      mark_tx = cyc; mark_rx = cyc;
      bound_tx = btx; bound_rx = brx;
   endtask

   task automatic push(input bit is_tx, input int iv, input string tag, input int n);
      exp_t e;
      e.iv = iv; e.tag = tag;
      for (int i = 0; i < n; i++) begin
         if (is_tx) q_tx.push_back(e);
         else       q_rx.push_back(e);
      end
   endtask

   task automatic drain();
      int waited = 0;
      while ((q_tx.size() > 0 || q_rx.size() > 0) && waited < 20000) begin
         @(posedge clk);
         waited++;
      end
      if (q_tx.size() > 0 || q_rx.size() > 0) begin
         check(0, "queue drain timeout", q_tx.size() + q_rx.size(), 0);
         q_tx.delete(); q_rx.delete();
      end
   endtask

   // watchdog
   initial begin
      #(8 * 200000);
      if (!done) begin
         check(0, "watchdog expired", 0, 1);
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      int n;
      repeat (5) @(posedge clk);
      @(negedge clk);
      check(!tx_tick && !rx_tick && !rx_os_tick, "R1 ticks low in reset",
            {tx_tick, rx_tick, rx_os_tick}, 0);
      @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
      check(!tx_tick && !rx_tick && !rx_os_tick, "R1 ticks low after reset",
            {tx_tick, rx_tick, rx_os_tick}, 0);

      // reload values: narrow P=16, A P=8, B P=4, C P=16
      wr(3'd0, 16'h00F0);
      wr(3'd1, 16'hFFF8);
      wr(3'd2, 16'hFFFC);
      wr(3'd3, 16'hFFF0);
      repeat (66000) @(posedge clk);

      // defaults: narrow source, halving off -> 16*32
      resync(0, 0);
      push(1, 512, "R1 default tx narrow /32", 3);
      push(0, 512, "R1 R2 default rx narrow /32", 3);
      drain();

      // rx to wide A: 8*16
      set_ctrl(2'b00, 2'b01, 1'b0);
      resync(0, 15 * 8);
      push(1, 512, "R4 tx stays on narrow", 2);
      push(0, 128, "R3 R4 rx on wide A /16", 3);
      drain();

      // halving on: narrow /16
      set_ctrl(2'b00, 2'b01, 1'b1);
      resync(0, 0);
      push(1, 256, "R5 narrow halving bit set /16", 3);
      push(0, 128, "R6 wide A ignores halving", 2);
      drain();

      // tx wide B (P=4), rx wide C (P=16)
      set_ctrl(2'b10, 2'b11, 1'b1);
      resync(15 * 4, 15 * 16);
      push(1, 64, "R3 R4 tx on wide B", 3);
      push(0, 256, "R3 R4 rx on wide C", 3);
      drain();

      // halving cleared without select change: streams unchanged
      set_ctrl(2'b10, 2'b11, 1'b0);
      push(1, 64, "R6 tx wide B halving cleared", 3);
      push(0, 256, "R6 rx wide C halving cleared", 3);
      drain();

      // narrow enable every other cycle, halving on -> 2*16*16
      set_ctrl(2'b00, 2'b00, 1'b1);
      en_toggle = 1;
      resync(0, 0);
      push(1, 512, "R9 tx with half-rate enable", 2);
      push(0, 512, "R9 rx with half-rate enable", 2);
      drain();
      en_toggle = 0;

      // reload change mid-period: old period completes, then new one
      resync(0, 0);
      repeat (40) @(posedge clk);
      @(negedge clk);
      while (!rx_os_tick) @(negedge clk);
      fork
         begin
            repeat (3) @(posedge clk);
            wr(3'd0, 16'h00E0);
         end
      join_none
      n = 0;
      do begin @(negedge clk); n++; end while (!rx_os_tick);
      check(n == 16, "R10 period in progress keeps old reload", n, 16);
      n = 0;
      do begin @(negedge clk); n++; end while (!rx_os_tick);
      check(n == 32, "R10 new reload after rollover", n, 32);
      n = 0;
      do begin @(negedge clk); n++; end while (!rx_os_tick);
      check(n == 32, "R2 narrow period 256-reload", n, 32);

      check(wide_ticks == 0, "R8 ticks one cycle wide", wide_ticks, 0);

      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule